// File: doc/BRIEF.md
# Multithreaded Reorder Buffer with Squash

This block keeps the in-flight instructions of several hardware threads in program order until they can retire. The front end allocates an entry by presenting a thread number and a sequence number. The block answers with an entry index. Execution units later report completion by that index. A single commit port offers the oldest ready entry, and a back-pressure handshake removes it. Each thread owns a circular queue. An occupancy cap, chosen by a policy input, limits how many of the shared entries a thread may hold.

A branch misprediction raises a squash request that carries a thread number and a boundary sequence number. The block then walks that thread's queue from the youngest entry towards the oldest. Each cycle it marks at most `SQW` entries whose sequence number is younger than the boundary, and it keeps the walk position in a register between cycles. Marked entries stay in place. They leave later through the commit port, with the architectural-commit flag low. When the walk ends, a one-cycle done pulse is raised for that thread.

The allocation port is valid/ready. `al_ready` is a combinational function of the current state and of `al_tid`. A beat moves only when `al_valid` and `al_ready` are both high. The requester must wait for `al_ready`. A beat offered while it is low is dropped and flagged. The commit port is also valid/ready. `cm_valid` does not depend on `cm_ready`, and one entry leaves per cycle when both are high. `DEPTH` must be a power of two.

Top module: `rob_mt`

## Requirements
- R1: `al_ready` is high only when all of the following hold: total occupancy is below `DEPTH`; the thread's occupancy is below its cap; the thread is not squashing; and no squash request for that thread is present in the same cycle. The entry index is `{tid, slot}`, and `slot` advances by one per accepted allocation of that thread, starting at 0 after reset.
- R2: An allocation offered while `al_ready` is low changes no state. `al_err` is high in the following cycle.
- R3: A completion at index `{tid, slot}` marks that entry done. A thread's head is ready when the thread is active and its head entry is done or squashed.
- R4: `cm_valid` is high when any active thread's head is ready. The lowest such thread number is presented. One entry retires per cycle on `cm_valid && cm_ready`, and within a thread entries retire in allocation order.
- R5: `cm_arch` is high when the presented head is not squashed, and low when it is squashed.
- R6: Policy 0 (dynamic) gives each active thread a cap of `DEPTH`. Policy 1 (partitioned) gives `DEPTH` divided by the number of active threads. Policy 2 (threshold) gives `DEPTH*THR_PCT/100`. Inactive threads get a cap of 0. `free_total` equals `DEPTH` minus total occupancy. Each `free_thr` field (`CW` bits per thread, thread 0 lowest) equals cap minus occupancy, floored at 0.
- R7: `buf_full` is high exactly when total occupancy equals `DEPTH`. `thr_empty[t]` is high when thread t holds no entries.
- R8: A squash request starts a walk in the next cycle. Each cycle the walk marks up to `SQW` entries, youngest first. It stops at the first entry that is not younger than the boundary, or when it reaches the head. With N younger entries, the thread stays in the squashing state for floor(N/SQW)+1 cycles. `sq_done[t]` pulses in the first cycle after the walk ends, and the thread's head is never ready while it squashes.
- R9: `thr_state` holds 2 bits per thread: 0 idle (no entries), 1 running (has entries), 2 squashing. After the walk ends, the state is 1 if the thread still holds entries and 0 otherwise.
- R10: An entry is younger when its sequence number minus the boundary, taken modulo 2^SEQW, is nonzero and its top bit is clear. This keeps the comparison valid across sequence-number wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 2 | Sharing policy: 0 dynamic, 1 partitioned, 2 threshold |
| thr_active | input | NT | Active-thread mask |
| al_valid | input | 1 | Allocation offered |
| al_ready | output | 1 | Allocation can be accepted |
| al_tid | input | TW | Allocating thread |
| al_seq | input | SEQW | Sequence number of the new entry |
| al_idx | output | TW+PW | Index given to the offered entry |
| al_err | output | 1 | Rejected allocation in the previous cycle |
| cp_valid | input | 1 | Completion strobe |
| cp_idx | input | TW+PW | Index of the completed entry |
| cm_valid | output | 1 | A head entry is ready to retire |
| cm_ready | input | 1 | Consumer takes the presented entry |
| cm_tid | output | TW | Thread of the presented entry |
| cm_seq | output | SEQW | Sequence number of the presented entry |
| cm_arch | output | 1 | Presented entry commits architecturally (not squashed) |
| head_rdy | output | NT | Per-thread head-ready flag |
| sq_req | input | 1 | Squash request |
| sq_tid | input | TW | Thread to squash |
| sq_seq | input | SEQW | Boundary sequence number |
| sq_done | output | NT | Per-thread walk-finished pulse |
| thr_state | output | 2*NT | Per-thread state code |
| buf_full | output | 1 | Total occupancy equals DEPTH |
| thr_empty | output | NT | Per-thread empty flag |
| free_total | output | CW | Free entries in the whole buffer |
| free_thr | output | NT*CW | Per-thread free count |

## Verification
Most corrupted internal states show up at the ports within one or two cycles. A drifting head or tail pointer changes `free_total`, `free_thr` and the index in `al_idx` on the very next allocation. A lost done or squash mark either stalls `cm_valid` or flips `cm_arch` when that entry reaches the head. A walk pointer that advances too far or stops too early changes the number of cycles spent in the squashing state. It also changes `cm_arch` for the entries next to the boundary. The bench therefore counts squash cycles exactly, and it retires entries across the boundary one by one.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_RUN  = 2'd1,
    TS_SQ   = 2'd2
  } thr_state_e;

  typedef enum logic [1:0] {
    POL_DYN  = 2'd0,
    POL_PART = 2'd1,
    POL_THR  = 2'd2
  } share_pol_e;
endpackage

// File: rtl/rob_thread_q.sv
module rob_thread_q #(
  parameter int DEPTH = 16,
  parameter int SEQW  = 8,
  parameter int SQW   = 2,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_en,
  input  logic [SEQW-1:0] alloc_seq,
  output logic [PW-1:0]   tail_slot,
  input  logic            cmp_en,
  input  logic [PW-1:0]   cmp_slot,
  input  logic            ret_en,
  input  logic            sq_start,
  input  logic [SEQW-1:0] sq_bnd,
  output logic            head_rdy,
  output logic [SEQW-1:0] head_seq,
  output logic            head_sq,
  output logic [CW-1:0]   count,
  output logic            walking,
  output logic            sq_done
);
  logic [SEQW-1:0] seq_q [DEPTH];
  logic [DEPTH-1:0] done_q, sqd_q;
  logic [CW-1:0] hd, tl, wp, w_nx;
  logic [SEQW-1:0] bnd;
  logic stop;
  logic [DEPTH-1:0] mk;

  function automatic logic younger(input logic [SEQW-1:0] a, input logic [SEQW-1:0] b);
    logic [SEQW-1:0] d;
    d = a - b;
    return (d != '0) && !d[SEQW-1];
  endfunction

  assign count     = tl - hd;
  assign tail_slot = tl[PW-1:0];
  assign head_seq  = seq_q[hd[PW-1:0]];
  assign head_sq   = sqd_q[hd[PW-1:0]];
  assign head_rdy  = (count != '0) && !walking &&
                     (done_q[hd[PW-1:0]] || sqd_q[hd[PW-1:0]]);

  // Bounded backward walk: up to SQW entries per cycle, youngest first.
  always_comb begin
    logic [PW-1:0] s;
    w_nx = wp;
    stop = 1'b0;
    mk   = '0;
    for (int k = 0; k < SQW; k++) begin
      if (!stop) begin
        s = w_nx[PW-1:0] - PW'(1);
        if (w_nx == hd || !younger(seq_q[s], bnd)) begin
          stop = 1'b1;
        end else begin
          mk[s] = 1'b1;
          w_nx  = w_nx - CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) seq_q[tl[PW-1:0]] <= alloc_seq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hd <= '0; tl <= '0; wp <= '0; bnd <= '0;
      done_q <= '0; sqd_q <= '0;
      walking <= 1'b0; sq_done <= 1'b0;
    end else begin
      sq_done <= 1'b0;
      if (sq_start) begin
        walking <= 1'b1;
        wp      <= tl;
        bnd     <= sq_bnd;
      end else if (walking) begin
        wp    <= w_nx;
        sqd_q <= sqd_q | mk;
        if (stop) begin
          walking <= 1'b0;
          sq_done <= 1'b1;
        end
      end
      if (cmp_en) done_q[cmp_slot] <= 1'b1;
      if (alloc_en) begin
        done_q[tl[PW-1:0]] <= 1'b0;
        sqd_q[tl[PW-1:0]]  <= 1'b0;
        tl <= tl + CW'(1);
      end
      if (ret_en) hd <= hd + CW'(1);
    end
  end
endmodule

// File: rtl/rob_cap_calc.sv
module rob_cap_calc #(
  parameter int NT      = 2,
  parameter int DEPTH   = 16,
  parameter int THR_PCT = 75,
  localparam int CW     = $clog2(DEPTH) + 1
) (
  input  logic [1:0]     policy,
  input  logic [NT-1:0]  active,
  output logic [NT*CW-1:0] cap
);
  import rob_pkg::*;
  localparam int THR_CAP = DEPTH * THR_PCT / 100;

  logic [CW-1:0] part;

  always_comb begin
    int nact;
    nact = 0;
    for (int t = 0; t < NT; t++) nact += int'(active[t]);
    part = '0;
    for (int n = 1; n <= NT; n++) if (nact == n) part = CW'(DEPTH / n);
  end

  for (genvar t = 0; t < NT; t++) begin : g_cap
    always_comb begin
      if (!active[t]) cap[t*CW +: CW] = '0;
      else begin
        case (share_pol_e'(policy))
          POL_PART: cap[t*CW +: CW] = part;
          POL_THR:  cap[t*CW +: CW] = CW'(THR_CAP);
          default:  cap[t*CW +: CW] = CW'(DEPTH);
        endcase
      end
    end
  end
endmodule

// File: rtl/rob_commit_sel.sv
module rob_commit_sel #(
  parameter int NT = 2,
  parameter int TW = 1
) (
  input  logic [NT-1:0] rdy,
  output logic          any,
  output logic [TW-1:0] sel
);
  always_comb begin
    sel = '0;
    for (int t = NT - 1; t >= 0; t--) if (rdy[t]) sel = TW'(t);
    any = |rdy;
  end
endmodule

// File: rtl/rob_mt.sv
module rob_mt #(
  parameter int NT      = 2,
  parameter int DEPTH   = 16,
  parameter int SEQW    = 8,
  parameter int SQW     = 2,
  parameter int THR_PCT = 75,
  localparam int TW     = (NT > 1) ? $clog2(NT) : 1,
  localparam int PW     = $clog2(DEPTH),
  localparam int CW     = PW + 1,
  localparam int IW     = TW + PW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       policy,
  input  logic [NT-1:0]    thr_active,
  input  logic             al_valid,
  output logic             al_ready,
  input  logic [TW-1:0]    al_tid,
  input  logic [SEQW-1:0]  al_seq,
  output logic [IW-1:0]    al_idx,
  output logic             al_err,
  input  logic             cp_valid,
  input  logic [IW-1:0]    cp_idx,
  output logic             cm_valid,
  input  logic             cm_ready,
  output logic [TW-1:0]    cm_tid,
  output logic [SEQW-1:0]  cm_seq,
  output logic             cm_arch,
  output logic [NT-1:0]    head_rdy,
  input  logic             sq_req,
  input  logic [TW-1:0]    sq_tid,
  input  logic [SEQW-1:0]  sq_seq,
  output logic [NT-1:0]    sq_done,
  output logic [2*NT-1:0]  thr_state,
  output logic             buf_full,
  output logic [NT-1:0]    thr_empty,
  output logic [CW-1:0]    free_total,
  output logic [NT*CW-1:0] free_thr
);
  import rob_pkg::*;

  logic [CW-1:0]   cnt   [NT];
  logic [PW-1:0]   tslot [NT];
  logic [SEQW-1:0] hseq  [NT];
  logic [NT-1:0]   q_rdy, hsq, walking;
  logic [NT*CW-1:0] cap;
  logic [CW-1:0]   total;
  logic            al_fire, ret_fire;
  logic [TW-1:0]   cp_tid;

  assign cp_tid = cp_idx[IW-1:PW];

  rob_cap_calc #(.NT(NT), .DEPTH(DEPTH), .THR_PCT(THR_PCT)) u_cap (
    .policy(policy), .active(thr_active), .cap(cap)
  );

  for (genvar t = 0; t < NT; t++) begin : g_thr
    rob_thread_q #(.DEPTH(DEPTH), .SEQW(SEQW), .SQW(SQW)) u_q (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(al_fire && al_tid == TW'(t)),
      .alloc_seq(al_seq),
      .tail_slot(tslot[t]),
      .cmp_en(cp_valid && cp_tid == TW'(t)),
      .cmp_slot(cp_idx[PW-1:0]),
      .ret_en(ret_fire && cm_tid == TW'(t)),
      .sq_start(sq_req && sq_tid == TW'(t)),
      .sq_bnd(sq_seq),
      .head_rdy(q_rdy[t]),
      .head_seq(hseq[t]),
      .head_sq(hsq[t]),
      .count(cnt[t]),
      .walking(walking[t]),
      .sq_done(sq_done[t])
    );

    logic [CW-1:0] cap_t;
    assign cap_t = cap[t*CW +: CW];
    assign free_thr[t*CW +: CW] = (cap_t > cnt[t]) ? cap_t - cnt[t] : '0;
    assign thr_empty[t] = (cnt[t] == '0);
    assign thr_state[2*t +: 2] = walking[t]      ? TS_SQ :
                                 (cnt[t] == '0)  ? TS_IDLE : TS_RUN;
    assign head_rdy[t] = q_rdy[t] && thr_active[t];
  end

  always_comb begin
    total = '0;
    for (int t = 0; t < NT; t++) total = total + cnt[t];
  end

  assign buf_full   = (total == CW'(DEPTH));
  assign free_total = CW'(DEPTH) - total;

  assign al_ready = !buf_full &&
                    (cnt[al_tid] < cap[al_tid*CW +: CW]) &&
                    !walking[al_tid] &&
                    !(sq_req && sq_tid == al_tid);
  assign al_fire  = al_valid && al_ready;
  assign al_idx   = {al_tid, tslot[al_tid]};

  always_ff @(posedge clk) begin
    if (!rst_n) al_err <= 1'b0;
    else        al_err <= al_valid && !al_ready;
  end

  rob_commit_sel #(.NT(NT), .TW(TW)) u_sel (
    .rdy(head_rdy), .any(cm_valid), .sel(cm_tid)
  );

  assign cm_seq   = hseq[cm_tid];
  assign cm_arch  = !hsq[cm_tid];
  assign ret_fire = cm_valid && cm_ready;
endmodule

// File: rtl/rob_mt_chk.sv
module rob_mt_chk #(
  parameter int NT = 2,
  parameter int TW = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            al_valid,
  input logic            al_ready,
  input logic [TW-1:0]   al_tid,
  input logic            al_err,
  input logic            cm_valid,
  input logic [TW-1:0]   cm_tid,
  input logic [NT-1:0]   head_rdy,
  input logic [NT-1:0]   sq_done,
  input logic [2*NT-1:0] thr_state,
  input logic            buf_full
);
  AST_FULL_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !al_ready); // R7
  AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (al_valid && !al_ready) |=> al_err); // R2
  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    al_err |-> $past(al_valid && !al_ready)); // R2
  AST_LOW_TID_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && head_rdy[0]) |-> cm_tid == '0); // R4

  for (genvar t = 0; t < NT; t++) begin : g_t
    AST_SQ_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_state[2*t +: 2] == 2'd2 && al_tid == TW'(t)) |-> !al_ready); // R1
    AST_SQ_NO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_state[2*t +: 2] == 2'd2) |-> !head_rdy[t]); // R8
    AST_DONE_LEAVES_SQ: assert property (@(posedge clk) disable iff (!rst_n)
      sq_done[t] |-> thr_state[2*t +: 2] != 2'd2); // R9
  end
endmodule

bind rob_mt rob_mt_chk #(.NT(NT), .TW(TW)) u_chk (.*);

// File: tb/tb_rob_mt.sv
`timescale 1ns/1ps
module tb_rob_mt;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] policy = '0;
  logic [1:0] thr_active = 2'b11;
  logic al_valid = 0, al_ready, al_err;
  logic [0:0] al_tid = '0, cm_tid, sq_tid = '0;
  logic [7:0] al_seq = '0, cm_seq, sq_seq = '0;
  logic [4:0] al_idx, cp_idx = '0, free_total;
  logic cp_valid = 0, cm_valid, cm_ready = 0, cm_arch, sq_req = 0, buf_full;
  logic [1:0] head_rdy, sq_done, thr_empty;
  logic [3:0] thr_state;
  logic [9:0] free_thr;
  int nchk = 0, nerr = 0;
  logic finished = 0;

  always #2.5 clk = ~clk;

  rob_mt dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step; @(posedge clk); #1; endtask

  task automatic do_reset(input logic [1:0] pol, input logic [1:0] act);
    rst_n = 0; policy = pol; thr_active = act;
    al_valid = 0; cp_valid = 0; cm_ready = 0; sq_req = 0;
    repeat (2) step;
    rst_n = 1; step;
  endtask

  task automatic alloc(input logic t, input logic [7:0] s);
    al_valid = 1; al_tid = t; al_seq = s; step; al_valid = 0;
  endtask

  task automatic complete(input logic [4:0] idx);
    cp_valid = 1; cp_idx = idx; step; cp_valid = 0;
  endtask

  task automatic commit; cm_ready = 1; step; cm_ready = 0; endtask

  task automatic squash(input logic t, input logic [7:0] s, input int exp_cyc);
    int n = 0;
    sq_req = 1; sq_tid = t; sq_seq = s; step; sq_req = 0;
    al_tid = t; #0.1;
    chk("R1 no alloc while squashing", al_ready, 0);
    while (thr_state[2*t +: 2] == 2'd2 && n < 50) begin n++; step; end
    chk("R8 squash cycles", n, exp_cyc);
    chk("R8 done pulse", sq_done[t], 1);
  endtask

  task automatic t_reset;
    do_reset(2'd0, 2'b11);
    chk("R1 ready after reset", al_ready, 1);
    chk("R6 free_total reset", free_total, 16);
    chk("R6 free_thr0 dynamic", free_thr[4:0], 16);
    chk("R9 idle after reset", thr_state, 0);
    chk("R4 no commit after reset", cm_valid, 0);
    chk("R7 empty after reset", thr_empty, 2'b11);
  endtask

  task automatic t_order;
    do_reset(2'd0, 2'b11);
    alloc(0, 1); alloc(0, 2);
    al_tid = 0; #0.1;
    chk("R1 third index", al_idx, 2);
    alloc(0, 3);
    complete(5'd2);
    chk("R3 head not done", cm_valid, 0);
    complete(5'd0);
    chk("R3 head done ready", cm_valid, 1);
    chk("R4 oldest first", cm_seq, 1);
    chk("R5 arch commit", cm_arch, 1);
    commit;
    chk("R4 next head not done", cm_valid, 0);
    chk("R9 running", thr_state[1:0], 1);
  endtask

  task automatic t_full;
    do_reset(2'd0, 2'b11);
    for (int i = 0; i < 16; i++) alloc(0, 8'(i));
    al_tid = 0; #0.1;
    chk("R7 full", buf_full, 1);
    chk("R1 not ready when full", al_ready, 0);
    chk("R6 free_total zero", free_total, 0);
    chk("R7 thread1 empty", thr_empty[1], 1);
    alloc(0, 8'd99);
    chk("R2 error flagged", al_err, 1);
    chk("R2 insert dropped", free_total, 0);
    step;
    chk("R2 error one cycle", al_err, 0);
  endtask

  task automatic t_policy;
    do_reset(2'd1, 2'b11);
    chk("R6 partitioned t0", free_thr[4:0], 8);
    chk("R6 partitioned t1", free_thr[9:5], 8);
    for (int i = 0; i < 8; i++) alloc(1, 8'(40 + i));
    al_tid = 1; #0.1;
    chk("R1 t1 at cap", al_ready, 0);
    al_tid = 0; #0.1;
    chk("R1 t0 below cap", al_ready, 1);
    chk("R6 free_total partial", free_total, 8);
    thr_active = 2'b01; #0.1;
    chk("R6 single active full share", free_thr[4:0], 16);
    chk("R6 inactive cap zero", free_thr[9:5], 0);
    policy = 2'd2; #0.1;
    chk("R6 threshold cap", free_thr[4:0], 12);
  endtask

  task automatic t_arb;
    do_reset(2'd0, 2'b11);
    alloc(1, 20); complete(5'd16);
    chk("R4 only t1 ready", cm_tid, 1);
    alloc(0, 30); complete(5'd0);
    chk("R4 lowest tid wins", cm_tid, 0);
    chk("R4 t0 seq", cm_seq, 30);
    commit;
    chk("R4 then t1", cm_tid, 1);
    chk("R4 t1 seq", cm_seq, 20);
  endtask

  task automatic t_squash;
    do_reset(2'd0, 2'b11);
    for (int i = 0; i < 8; i++) alloc(1, 8'(10 + i));
    complete(5'd16);
    squash(1, 8'd12, 3);
    chk("R9 running after squash", thr_state[3:2], 1);
    chk("R5 seq10 arch", cm_arch, 1);
    chk("R4 seq10 presented", cm_seq, 10);
    commit;
    chk("R3 seq11 not done", cm_valid, 0);
    complete(5'd17); complete(5'd18);
    chk("R5 seq11 arch", cm_arch, 1);
    commit;
    chk("R8 boundary kept", cm_arch, 1);
    chk("R8 boundary seq", cm_seq, 12);
    commit;
    chk("R3 squashed head ready", cm_valid, 1);
    chk("R5 squashed not arch", cm_arch, 0);
    chk("R8 first squashed seq", cm_seq, 13);
  endtask

  task automatic t_wrap;
    do_reset(2'd0, 2'b11);
    alloc(0, 254); alloc(0, 255); alloc(0, 0); alloc(0, 1);
    squash(0, 8'd255, 2);
    complete(5'd0); complete(5'd1);
    commit;
    chk("R10 older across wrap", cm_arch, 1);
    commit;
    chk("R10 seq0 younger than 255", cm_arch, 0);
    chk("R10 seq0 presented", cm_seq, 0);
  endtask

  task automatic t_squash_all;
    do_reset(2'd0, 2'b11);
    alloc(0, 5); alloc(0, 6); alloc(0, 7);
    squash(0, 8'd4, 2);
    chk("R9 running with marked entries", thr_state[1:0], 1);
    chk("R5 head squashed", cm_arch, 0);
    commit; commit; commit;
    chk("R9 idle after drain", thr_state[1:0], 0);
    chk("R7 empty after drain", thr_empty[0], 1);
  endtask

  initial begin
    t_reset; t_order; t_full; t_policy; t_arb; t_squash; t_wrap; t_squash_all;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule